// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block sits beside one processor and keeps a small direct-mapped table of cached objects. Each line holds an object identifier, a data value and one of three coherence states: Invalid, Read-only or Exclusive. The processor reads and writes objects through a valid/ready handshake. Hits are served locally. Misses and write upgrades become messages on a shared broadcast bus, and those messages are issued through a request/grant pair toward an external arbiter.

The controller watches every message that other nodes put on the bus. It invalidates its copy when it sees a foreign write-request. It answers a foreign read-request with a value-response when it holds the object. It picks up any value-response into an Invalid line. When several nodes hold the same object, a fixed priority lets only the lowest-numbered holder drive the answer. Each node reports whether it holds the snooped object, and each node sees the holder flags of all the others.

A read miss blocks until the matching value-response appears on the bus. A write that loses arbitration to another node's write of the same object is re-evaluated and retried. Writes are never written back, because the table keeps no dirty state.

Top module: `snc_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, every line is Invalid, `req_o` is 0 and `holder_o` is 0. A processor read of any id is then not answered with `cpu_rdy` without bus traffic.
- R2: A processor read whose id matches a Read-only or Exclusive line raises `cpu_rdy` in the same cycle, with `cpu_rdata` equal to the stored value and `req_o` low. A line is selected by the low log2(ENTRIES) bits of the id and matches only if its full stored id is equal.
- R3: A read miss raises `req_o` on the next cycle with `req_kind`=1 (read-request) and `req_id` equal to the id. After `bus_gnt`, the controller waits. It completes one cycle after a foreign value-response (`bus_kind`=3) with the same id, returning that response's value.
- R4: A processor write to a line that is Read-only or Invalid raises `req_o` with `req_kind`=2 (write-request), carrying the id and new value. The line becomes Exclusive with the new value when `bus_gnt` is seen, and `cpu_rdy` rises on the following cycle.
- R5: A processor write that hits an Exclusive line completes in the same cycle with no bus request, and it updates the stored value.
- R6: A foreign write-request for a held id moves that line to Invalid, so a later read of that id misses. A foreign write-request has no effect on a line that is already Invalid.
- R7: A foreign read-request (`bus_kind`=1) for a held id raises `holder_o` in the same cycle. If no lower-numbered node holds the id, the next cycle shows a value-response request (`req_kind`=3) carrying the stored value. An Exclusive line that is snooped this way drops to Read-only.
- R8: When any `holders_i` bit below NODE_ID is set during a snooped read-request, no value-response is requested. Higher-numbered holders do not suppress the response.
- R9: A foreign value-response whose id maps to an Invalid line loads that id and value, and the line becomes Read-only.
- R10: A pending write whose request sees a foreign write-request for the same line before its grant drops the request for one cycle and then reissues it. After the grant, the line ends Exclusive with this node's value.
- R11: Bus messages with `bus_src` equal to NODE_ID are ignored by the snoop logic. A pending value-response takes priority over the node's own request on `req_*`, and the processor is not answered while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_vld | input | 1 | Processor request valid, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_id | input | ID_W | Object identifier of the request |
| cpu_wdata | input | VAL_W | Write value |
| cpu_rdy | output | 1 | Request completes this cycle |
| cpu_rdata | output | VAL_W | Read value, valid with `cpu_rdy` on a read |
| req_o | output | 1 | Bus request to the arbiter |
| req_kind | output | 2 | Message kind: 1 read-request, 2 write-request, 3 value-response |
| req_id | output | ID_W | Message object id |
| req_val | output | VAL_W | Message value (meaningful for kinds 2 and 3) |
| bus_gnt | input | 1 | The presented message is granted this cycle |
| bus_kind | input | 2 | Snooped message kind, 0 = bus idle |
| bus_src | input | SRC_W | Node number of the snooped message's sender |
| bus_id | input | ID_W | Snooped object id |
| bus_val | input | VAL_W | Snooped value |
| holder_o | output | 1 | This node holds the id of the snooped read-request |
| holders_i | input | NODES | Holder flags of all nodes, indexed by node number |

## Verification
A wrong line state shows up at the ports on the next access to that object. A stale Exclusive line completes a write with no request where a write-request is expected. A line left valid after a foreign write-request answers a read with `cpu_rdy` in the same cycle instead of raising a read-request one cycle later. A missed downgrade or suppression appears one cycle after a snooped read-request, as a value-response request that is present when it should be absent or the reverse. A lost retry appears as a wrong read-back value in the cycle of the next hit.

// File: rtl/snc_pkg.sv
// Shared encodings for the snooping coherence controller.
// Assumes a two-bit message kind field on the bus, with 0 meaning idle.
package snc_pkg;
    typedef enum logic [1:0] {
        MSG_NONE   = 2'd0,
        MSG_RDREQ  = 2'd1,
        MSG_WRREQ  = 2'd2,
        MSG_VALRSP = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_RO  = 2'd1,
        ST_EX  = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_REQ  = 2'd1,
        C_WAIT = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/snc_table.sv
// Direct-mapped line table with one snoop port and one processor port.
// The snoop port computes its own state change from a foreign message.
// The processor write port wins when both ports target the same line.
// Assumes ENTRIES is a power of two and at least 2.
module snc_table
    import snc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 8,
    parameter int VAL_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sn_vld,
    input  logic [1:0]       sn_kind,
    input  logic [ID_W-1:0]  sn_id,
    input  logic [VAL_W-1:0] sn_val,
    output logic             sn_hit,
    output logic [VAL_W-1:0] sn_rval,
    input  logic [ID_W-1:0]  c_id,
    output logic [1:0]       c_st,
    output logic [VAL_W-1:0] c_val,
    input  logic             c_we,
    input  logic [1:0]       c_wst,
    input  logic [VAL_W-1:0] c_wval
);
    logic [ID_W-1:0]  tag_q [ENTRIES];
    logic [VAL_W-1:0] val_q [ENTRIES];
    logic [1:0]       st_q  [ENTRIES];

    logic [IDX_W-1:0] sn_idx, c_idx;
    logic [1:0]       sn_cur, sn_nst;
    logic [ID_W-1:0]  sn_ntag;
    logic [VAL_W-1:0] sn_nval;
    logic             sn_upd;

    // Snoop lookup: does a valid line hold the snooped id?
    always_comb begin
        sn_idx  = sn_id[IDX_W-1:0];
        sn_cur  = st_q[sn_idx];
        sn_hit  = sn_vld && (sn_cur != ST_INV) && (tag_q[sn_idx] == sn_id);
        sn_rval = val_q[sn_idx];
    end

    // Snoop update: invalidate, downgrade or pick up a value.
    always_comb begin
        sn_upd  = 1'b0;
        sn_nst  = sn_cur;
        sn_ntag = tag_q[sn_idx];
        sn_nval = val_q[sn_idx];
        if (sn_vld) begin
            case (sn_kind)
                MSG_WRREQ: if (sn_hit) begin
                    sn_upd = 1'b1;
                    sn_nst = ST_INV;
                end
                MSG_RDREQ: if (sn_hit && sn_cur == ST_EX) begin
                    sn_upd = 1'b1;
                    sn_nst = ST_RO;
                end
                MSG_VALRSP: if (sn_cur == ST_INV) begin
                    sn_upd  = 1'b1;
                    sn_nst  = ST_RO;
                    sn_ntag = sn_id;
                    sn_nval = sn_val;
                end
                default: ;
            endcase
        end
    end

    // Processor lookup: state reads Invalid unless the full id matches.
    always_comb begin
        c_idx = c_id[IDX_W-1:0];
        c_st  = (st_q[c_idx] != ST_INV && tag_q[c_idx] == c_id) ? st_q[c_idx] : ST_INV;
        c_val = val_q[c_idx];
    end

    // Line storage: the processor port has priority over the snoop port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]  <= ST_INV;
                tag_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (c_we && c_idx == IDX_W'(i)) begin
                    st_q[i]  <= c_wst;
                    tag_q[i] <= c_id;
                    val_q[i] <= c_wval;
                end else if (sn_upd && sn_idx == IDX_W'(i)) begin
                    st_q[i]  <= sn_nst;
                    tag_q[i] <= sn_ntag;
                    val_q[i] <= sn_nval;
                end
            end
        end
    end
endmodule

// File: rtl/snc_lower.sv
// Fixed-priority responder check: reports whether any node numbered below
// NODE_ID also holds the snooped object. Node 0 always answers.
module snc_lower #(
    parameter int NODES   = 4,
    parameter int NODE_ID = 1
) (
    input  logic [NODES-1:0] holders,
    output logic             lower_any
);
    generate
        if (NODE_ID == 0) begin : g_top_prio
            logic unused_h;
            assign unused_h  = |holders;
            assign lower_any = 1'b0;
        end else begin : g_scan
            logic unused_h;
            assign unused_h  = |holders[NODES-1:NODE_ID];
            assign lower_any = |holders[NODE_ID-1:0];
        end
    endgenerate
endmodule

// File: rtl/snc_ctrl.sv
// Per-processor three-state snooping coherence controller.
// Serves processor reads and writes from the line table, issues read-,
// write- and value-response messages through a request/grant pair, and
// reacts to foreign bus messages. Assumes the arbiter grants one message
// per cycle and that a read-request is answered before any other message.
// The processor must hold cpu_vld and its fields stable until cpu_rdy.
module snc_ctrl
    import snc_pkg::*;
#(
    parameter int NODES   = 4,
    parameter int NODE_ID = 1,
    parameter int ENTRIES = 4,
    parameter int ID_W    = 8,
    parameter int VAL_W   = 16,
    localparam int SRC_W  = $clog2(NODES),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_vld,
    input  logic             cpu_we,
    input  logic [ID_W-1:0]  cpu_id,
    input  logic [VAL_W-1:0] cpu_wdata,
    output logic             cpu_rdy,
    output logic [VAL_W-1:0] cpu_rdata,
    output logic             req_o,
    output logic [1:0]       req_kind,
    output logic [ID_W-1:0]  req_id,
    output logic [VAL_W-1:0] req_val,
    input  logic             bus_gnt,
    input  logic [1:0]       bus_kind,
    input  logic [SRC_W-1:0] bus_src,
    input  logic [ID_W-1:0]  bus_id,
    input  logic [VAL_W-1:0] bus_val,
    output logic             holder_o,
    input  logic [NODES-1:0] holders_i
);
    ctl_st_e          st_q, st_d;
    logic             foreign, stall, sn_hit, lower_any, capture;
    logic [VAL_W-1:0] sn_rval, c_val;
    logic [1:0]       c_st, c_wst;
    logic             c_we, hit_ok, own_gnt;
    logic             resp_pend;
    logic [ID_W-1:0]  resp_id;
    logic [VAL_W-1:0] resp_val;
    logic [VAL_W-1:0] c_wval;

    // Bus qualification: only other nodes' messages are snooped.
    always_comb begin
        foreign  = (bus_kind != MSG_NONE) && (bus_src != SRC_W'(NODE_ID));
        stall    = foreign && (bus_id[IDX_W-1:0] == cpu_id[IDX_W-1:0]);
        holder_o = foreign && (bus_kind == MSG_RDREQ) && sn_hit;
        capture  = holder_o && !lower_any;
    end

    snc_table #(.ENTRIES(ENTRIES), .ID_W(ID_W), .VAL_W(VAL_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .sn_vld  (foreign),
        .sn_kind (bus_kind),
        .sn_id   (bus_id),
        .sn_val  (bus_val),
        .sn_hit  (sn_hit),
        .sn_rval (sn_rval),
        .c_id    (cpu_id),
        .c_st    (c_st),
        .c_val   (c_val),
        .c_we    (c_we),
        .c_wst   (c_wst),
        .c_wval  (c_wval)
    );

    snc_lower #(.NODES(NODES), .NODE_ID(NODE_ID)) u_low (
        .holders   (holders_i),
        .lower_any (lower_any)
    );

    // Processor side: hit test, completion and table writes.
    always_comb begin
        hit_ok    = cpu_we ? (c_st == ST_EX) : (c_st != ST_INV);
        cpu_rdy   = (st_q == C_IDLE) && cpu_vld && !resp_pend && !stall && hit_ok;
        cpu_rdata = c_val;
        own_gnt   = bus_gnt && !resp_pend && (st_q == C_REQ);
        c_we      = 1'b0;
        c_wst     = ST_EX;
        c_wval    = cpu_wdata;
        if (cpu_rdy && cpu_we) begin
            c_we = 1'b1;
        end else if (own_gnt) begin
            c_we = 1'b1;
            if (!cpu_we) begin
                c_wst  = ST_INV;
                c_wval = c_val;
            end
        end
    end

    // Request mux: a pending value-response overrides the node's own message.
    always_comb begin
        req_o    = resp_pend || (st_q == C_REQ);
        req_kind = resp_pend ? MSG_VALRSP : (cpu_we ? MSG_WRREQ : MSG_RDREQ);
        req_id   = resp_pend ? resp_id  : cpu_id;
        req_val  = resp_pend ? resp_val : cpu_wdata;
    end

    // Controller sequencing: idle, requesting the bus, waiting for a value.
    always_comb begin
        st_d = st_q;
        case (st_q)
            C_IDLE: if (cpu_vld && !resp_pend && !stall && !hit_ok) st_d = C_REQ;
            C_REQ: begin
                if (own_gnt)    st_d = cpu_we ? C_IDLE : C_WAIT;
                else if (stall) st_d = C_IDLE;
            end
            C_WAIT: if (foreign && bus_kind == MSG_VALRSP && bus_id == cpu_id) st_d = C_IDLE;
            default: st_d = C_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    // Response holder: capture on a won snoop, release on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_pend <= 1'b0;
            resp_id   <= '0;
            resp_val  <= '0;
        end else if (capture) begin
            resp_pend <= 1'b1;
            resp_id   <= bus_id;
            resp_val  <= sn_rval;
        end else if (bus_gnt && resp_pend) begin
            resp_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/snc_ctrl_chk.sv
// Protocol checker for snc_ctrl, attached by bind. Observes ports only.
module snc_ctrl_chk #(
    parameter int NODES   = 4,
    parameter int NODE_ID = 1,
    localparam int SRC_W  = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_vld,
    input logic             cpu_rdy,
    input logic             req_o,
    input logic [1:0]       req_kind,
    input logic [1:0]       bus_kind,
    input logic [SRC_W-1:0] bus_src,
    input logic             holder_o,
    input logic [NODES-1:0] holders_i
);
    logic lower_seen;

    // Independent view of a lower-numbered holder.
    always_comb begin
        lower_seen = 1'b0;
        for (int j = 0; j < NODES; j++)
            if (j < NODE_ID && holders_i[j]) lower_seen = 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!req_o && !holder_o));

    a_r2_rdy_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> cpu_vld);

    a_r3_no_rdy_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !cpu_rdy);

    a_r7_holder_on_foreign_rr: assert property (@(posedge clk) disable iff (!rst_n)
        holder_o |-> (bus_kind == 2'd1 && bus_src != SRC_W'(NODE_ID)));

    a_r7_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (holder_o && !lower_seen) |=> (req_o && req_kind == 2'd3));

    a_r11_kind_nonidle: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_kind != 2'd0));
endmodule

bind snc_ctrl snc_ctrl_chk #(.NODES(NODES), .NODE_ID(NODE_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_vld   (cpu_vld),
    .cpu_rdy   (cpu_rdy),
    .req_o     (req_o),
    .req_kind  (req_kind),
    .bus_kind  (bus_kind),
    .bus_src   (bus_src),
    .holder_o  (holder_o),
    .holders_i (holders_i)
);

// File: tb/sim_snc_ctrl.sv
// Directed bench: the bench plays arbiter and the other nodes.
module sim_snc_ctrl;
    localparam int NODES = 4, NODE_ID = 1, ENTRIES = 4, ID_W = 8, VAL_W = 16;
    localparam int SRC_W = $clog2(NODES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_vld = 0, cpu_we = 0;
    logic [ID_W-1:0] cpu_id = '0;
    logic [VAL_W-1:0] cpu_wdata = '0;
    logic cpu_rdy;
    logic [VAL_W-1:0] cpu_rdata;
    logic req_o;
    logic [1:0] req_kind;
    logic [ID_W-1:0] req_id;
    logic [VAL_W-1:0] req_val;
    logic bus_gnt = 0;
    logic [1:0] bus_kind = 0;
    logic [SRC_W-1:0] bus_src = 0;
    logic [ID_W-1:0] bus_id = 0;
    logic [VAL_W-1:0] bus_val = 0;
    logic holder_o;
    logic [NODES-1:0] holders_i = 0;

    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    snc_ctrl #(.NODES(NODES), .NODE_ID(NODE_ID), .ENTRIES(ENTRIES), .ID_W(ID_W), .VAL_W(VAL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_vld(cpu_vld), .cpu_we(cpu_we), .cpu_id(cpu_id),
        .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .req_o(req_o),
        .req_kind(req_kind), .req_id(req_id), .req_val(req_val), .bus_gnt(bus_gnt),
        .bus_kind(bus_kind), .bus_src(bus_src), .bus_id(bus_id), .bus_val(bus_val),
        .holder_o(holder_o), .holders_i(holders_i));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic bus_put(input logic [1:0] k, input int src, input logic [ID_W-1:0] id, input logic [VAL_W-1:0] v);
        bus_kind = k; bus_src = SRC_W'(src); bus_id = id; bus_val = v;
    endtask

    task automatic bus_idle();
        bus_kind = 0; bus_src = 0; bus_id = 0; bus_val = 0;
    endtask

    // Read that must hit in the same cycle.
    task automatic read_hit(input string tag, input logic [ID_W-1:0] id, input logic [VAL_W-1:0] exp);
        @(negedge clk); cpu_vld = 1; cpu_we = 0; cpu_id = id; #1;
        chk({tag, " rdy"}, 32'(cpu_rdy), 1);
        chk({tag, " rdata"}, 32'(cpu_rdata), 32'(exp));
        chk({tag, " no req"}, 32'(req_o), 0);
        @(posedge clk); #1 cpu_vld = 0;
    endtask

    // Read miss answered by another node's value-response.
    task automatic read_miss(input string tag, input logic [ID_W-1:0] id, input logic [VAL_W-1:0] v);
        @(negedge clk); cpu_vld = 1; cpu_we = 0; cpu_id = id; #1;
        chk({tag, " miss no rdy"}, 32'(cpu_rdy), 0);
        @(negedge clk); #1;
        chk({tag, " rr req"}, 32'(req_o), 1);
        chk({tag, " rr kind"}, 32'(req_kind), 1);
        chk({tag, " rr id"}, 32'(req_id), 32'(id));
        bus_gnt = 1;
        @(negedge clk); bus_gnt = 0; #1;
        chk({tag, " waiting"}, 32'(cpu_rdy), 0);
        bus_put(2'd3, 2, id, v);
        @(negedge clk); bus_idle(); #1;
        chk({tag, " done rdy"}, 32'(cpu_rdy), 1);
        chk({tag, " done data"}, 32'(cpu_rdata), 32'(v));
        @(posedge clk); #1 cpu_vld = 0;
    endtask

    // Write that must go to the bus first.
    task automatic write_bus(input string tag, input logic [ID_W-1:0] id, input logic [VAL_W-1:0] v);
        @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_id = id; cpu_wdata = v; #1;
        chk({tag, " no rdy"}, 32'(cpu_rdy), 0);
        @(negedge clk); #1;
        chk({tag, " wr kind"}, 32'(req_o ? req_kind : 2'd0), 2);
        chk({tag, " wr val"}, 32'(req_val), 32'(v));
        bus_gnt = 1;
        @(negedge clk); bus_gnt = 0; #1;
        chk({tag, " rdy"}, 32'(cpu_rdy), 1);
        @(posedge clk); #1 cpu_vld = 0; cpu_we = 0;
    endtask

    // Write that must complete locally.
    task automatic write_local(input string tag, input logic [ID_W-1:0] id, input logic [VAL_W-1:0] v);
        @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_id = id; cpu_wdata = v; #1;
        chk({tag, " rdy"}, 32'(cpu_rdy), 1);
        chk({tag, " no req"}, 32'(req_o), 0);
        @(posedge clk); #1 cpu_vld = 0; cpu_we = 0;
    endtask

    // Foreign read-request; checks holder flag and the response.
    task automatic snoop_rr(input string tag, input logic [ID_W-1:0] id, input logic [NODES-1:0] h,
                            input logic exp_resp, input logic [VAL_W-1:0] v);
        @(negedge clk); bus_put(2'd1, 2, id, 0); holders_i = h; #1;
        chk({tag, " holder"}, 32'(holder_o), 1);
        @(negedge clk); bus_idle(); holders_i = 0; #1;
        chk({tag, " resp req"}, 32'(req_o), 32'(exp_resp));
        if (exp_resp) begin
            chk({tag, " resp kind"}, 32'(req_kind), 3);
            chk({tag, " resp val"}, 32'(req_val), 32'(v));
            bus_gnt = 1;
            @(negedge clk); bus_gnt = 0; #1;
            chk({tag, " resp done"}, 32'(req_o), 0);
        end
    endtask

    task automatic snoop_wr(input string tag, input logic [ID_W-1:0] id);
        @(negedge clk); bus_put(2'd2, 2, id, 16'h5555); #1;
        chk({tag, " holder"}, 32'(holder_o), 0);
        @(negedge clk); bus_idle(); #1;
        chk({tag, " no req"}, 32'(req_o), 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        chk("R1 req after reset", 32'(req_o), 0);
        chk("R1 holder after reset", 32'(holder_o), 0);
        cpu_vld = 1; cpu_we = 0; cpu_id = 8'h05; #1;
        chk("R1 empty table misses", 32'(cpu_rdy), 0);
        cpu_vld = 0;
    endtask

    task automatic t_lost_write();
        @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_id = 8'h09; cpu_wdata = 16'h7777; #1;
        chk("R10 no rdy", 32'(cpu_rdy), 0);
        @(negedge clk); #1;
        chk("R10 first wr kind", 32'(req_o ? req_kind : 2'd0), 2);
        bus_put(2'd2, 2, 8'h09, 16'h6666);
        @(negedge clk); bus_idle(); #1;
        chk("R10 request dropped", 32'(req_o), 0);
        @(negedge clk); #1;
        chk("R10 retry wr kind", 32'(req_o ? req_kind : 2'd0), 2);
        bus_gnt = 1;
        @(negedge clk); bus_gnt = 0; #1;
        chk("R10 retry rdy", 32'(cpu_rdy), 1);
        @(posedge clk); #1 cpu_vld = 0; cpu_we = 0;
        read_hit("R10 winner value", 8'h09, 16'h7777);
        write_local("R10 winner exclusive", 8'h09, 16'h7778);
    endtask

    task automatic t_resp_priority();
        @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_id = 8'h0E; cpu_wdata = 16'h4444; #1;
        chk("R11 no rdy", 32'(cpu_rdy), 0);
        @(negedge clk); #1;
        chk("R11 own wr", 32'(req_o ? req_kind : 2'd0), 2);
        bus_put(2'd1, 2, 8'h09, 0); #1;
        chk("R11 holder", 32'(holder_o), 1);
        @(negedge clk); bus_idle(); #1;
        chk("R11 resp first kind", 32'(req_kind), 3);
        chk("R11 resp id", 32'(req_id), 32'h09);
        chk("R11 resp val", 32'(req_val), 32'h7778);
        chk("R11 stalled", 32'(cpu_rdy), 0);
        bus_gnt = 1;
        @(negedge clk); #1;
        chk("R11 own wr after", 32'(req_kind), 2);
        chk("R11 own id after", 32'(req_id), 32'h0E);
        @(negedge clk); bus_gnt = 0; #1;
        chk("R11 write done", 32'(cpu_rdy), 1);
        @(posedge clk); #1 cpu_vld = 0; cpu_we = 0;
    endtask

    task automatic t_own_ignored();
        @(negedge clk); bus_put(2'd2, NODE_ID, 8'h05, 16'h1111);
        @(negedge clk); bus_idle();
        read_hit("R11 own msg ignored", 8'h05, 16'h0101);
        write_local("R11 still exclusive", 8'h05, 16'h0202);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        read_miss("R3 read miss", 8'h05, 16'h1234);
        read_hit("R2 read hit ro", 8'h05, 16'h1234);
        snoop_rr("R7 ro answers", 8'h05, 4'b0000, 1'b1, 16'h1234);
        snoop_rr("R8 lower suppresses", 8'h05, 4'b0001, 1'b0, 16'h0);
        snoop_rr("R8 higher no effect", 8'h05, 4'b0100, 1'b1, 16'h1234);
        write_bus("R4 upgrade", 8'h05, 16'hBEEF);
        read_hit("R2 read hit ex", 8'h05, 16'hBEEF);
        write_local("R5 local write", 8'h05, 16'hCAFE);
        read_hit("R5 value kept", 8'h05, 16'hCAFE);
        snoop_rr("R7 ex answers", 8'h05, 4'b0000, 1'b1, 16'hCAFE);
        write_bus("R7 downgraded to ro", 8'h05, 16'h0101);
        t_own_ignored();
        snoop_wr("R6 invalidate", 8'h05);
        read_miss("R6 miss after inval", 8'h05, 16'h3333);
        snoop_wr("R6 invalidate again", 8'h05);
        snoop_wr("R6 invalid ignores", 8'h05);
        @(negedge clk); bus_put(2'd3, 3, 8'h09, 16'h9999);
        @(negedge clk); bus_idle();
        read_hit("R9 pickup", 8'h09, 16'h9999);
        t_lost_write();
        t_resp_priority();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule